// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that completes one instruction per clock. On each rising edge the program counter moves to the next instruction address: the sequential one, a jump target, or a branch target. The core holds the program counter, a decoder that turns the 6-bit opcode into datapath controls, a 32-entry register file, sign extension and the write-back select. Its arithmetic unit is a separate submodule.

Instructions arrive on a combinational fetch port: the core drives an address and the word comes back in the same cycle. Loads and stores use a data port with address, write data, write enable, read enable and combinational read data. The register file is written on the falling edge. A value written by one instruction is therefore visible to the next, and the reads of the writing instruction are not disturbed before that edge.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter (`imem_addr`) to 0 and clears all 32 registers to zero.
- R2: Every instruction that is not a jump or a taken branch advances `imem_addr` by 4, and `imem_addr[1:0]` is always 0. The all-zero word has this effect and nothing else.
- R3: Opcode `000010` (bits 31:26) loads the program counter with bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R4: Opcode `011101` compares the registers named by bits 25:21 and 20:16. When they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by two. Otherwise the next PC is PC+4. It never writes a register or memory.
- R5: Opcode `000000` writes an ALU result into the register named by bits 15:11. The function is given by bits 5:0, with A the register at 25:21 and B the register at 20:16: `100000` A+B, `100010` A−B, `001101` A AND B, `001111` A OR B, `001011` NOT B.
- R6: Function `000010` shifts B left and `000011` shifts B right (logical), by the amount in instruction bits 10:6.
- R7: Function `011000` gives the low 32 bits of A×B. Function `011011` gives the unsigned quotient A/B, and all ones when B is zero.
- R8: An opcode-`000000` word whose function code is not listed in R5–R7 writes no register.
- R9: Opcodes `001100` and `001111` both write the register at bits 25:21 plus the sign-extended bits 15:0 into the register named by bits 20:16.
- R10: Opcode `100011` drives `dmem_addr` = base (bits 25:21) + sign-extended offset and asserts `dmem_re`, then writes `dmem_rdata` into the register at bits 20:16. Opcode `101011` drives the same address, asserts `dmem_we`, and puts the register at bits 20:16 on `dmem_wdata`.
- R11: Register 0 always reads as zero. Writes to it are discarded.
- R12: Any opcode not listed above writes neither a register nor memory. `dmem_we` is asserted only for the store opcode, and `dmem_we` and `dmem_re` are never high together.
- R13: Register writes take place on the falling clock edge, so an instruction that reads a register sees the value written by the instruction just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC on rising edge, registers on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory word address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the next rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |

## Verification
In one cycle, the falling-edge write-back of one instruction and the register reads of the next can touch the same register. So can the write and the read of a single instruction that uses one register as both source and destination. The program provokes this with an add-immediate that reads and rewrites its own register, and with a load followed at once by a branch whose comparator reads the loaded register. A behavioural reference model in the bench predicts the fetch address and every data-port strobe, address and store value on every clock. Register contents are brought out by stores and compared with the model. A missed or early write shows up as a wrong branch target or a wrong stored word.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam logic [5:0] OP_RTYPE = 6'b000000;
   localparam logic [5:0] OP_JUMP  = 6'b000010;
   localparam logic [5:0] OP_LWIM  = 6'b001111;
   localparam logic [5:0] OP_ADDI  = 6'b001100;
   localparam logic [5:0] OP_BEQ   = 6'b011101;
   localparam logic [5:0] OP_LW    = 6'b100011;
   localparam logic [5:0] OP_SW    = 6'b101011;

   localparam logic [5:0] FN_ADD  = 6'b100000;
   localparam logic [5:0] FN_SUB  = 6'b100010;
   localparam logic [5:0] FN_MUL  = 6'b011000;
   localparam logic [5:0] FN_DIV  = 6'b011011;
   localparam logic [5:0] FN_AND  = 6'b001101;
   localparam logic [5:0] FN_OR   = 6'b001111;
   localparam logic [5:0] FN_SRL  = 6'b000011;
   localparam logic [5:0] FN_SLL  = 6'b000010;
   localparam logic [5:0] FN_CMPL = 6'b001011;

   typedef struct packed {
      logic reg_we;
      logic dst_rd;
      logic src_imm;
      logic force_add;
      logic mem_to_reg;
      logic mem_re;
      logic mem_we;
      logic is_branch;
      logic is_jump;
   } ctl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctl_t       ctl
);
   always_comb begin
      ctl = '0;
      case (opcode)
         OP_RTYPE: begin
            ctl.reg_we = 1'b1;
            ctl.dst_rd = 1'b1;
         end
         OP_ADDI, OP_LWIM: begin
            ctl.reg_we    = 1'b1;
            ctl.src_imm   = 1'b1;
            ctl.force_add = 1'b1;
         end
         OP_LW: begin
            ctl.reg_we     = 1'b1;
            ctl.src_imm    = 1'b1;
            ctl.force_add  = 1'b1;
            ctl.mem_to_reg = 1'b1;
            ctl.mem_re     = 1'b1;
         end
         OP_SW: begin
            ctl.src_imm   = 1'b1;
            ctl.force_add = 1'b1;
            ctl.mem_we    = 1'b1;
         end
         OP_BEQ:  ctl.is_branch = 1'b1;
         OP_JUMP: ctl.is_jump   = 1'b1;
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W          = 32,
   parameter bit HAS_MULDIV = 1'b1
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [4:0]   shamt,
   input  logic [5:0]   funct,
   input  logic         force_add,
   output logic [W-1:0] y,
   output logic         ok
);
   logic [W-1:0] prod, quo;
   logic         md_en;

   generate
      if (HAS_MULDIV) begin : g_muldiv
         assign prod  = a * b;
         assign quo   = (b == '0) ? '1 : a / b;
         assign md_en = 1'b1;
      end else begin : g_no_muldiv
         assign prod  = '0;
         assign quo   = '0;
         assign md_en = 1'b0;
      end
   endgenerate

   always_comb begin
      y  = '0;
      ok = 1'b1;
      if (force_add) begin
         y = a + b;
      end else begin
         case (funct)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_CMPL: y = ~b;
            FN_SLL:  y = b << shamt;
            FN_SRL:  y = b >> shamt;
            FN_MUL:  begin y = prod; ok = md_en; end
            FN_DIV:  begin y = quo;  ok = md_en; end
            default: ok = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W = 32,
   parameter int N = 32,
   localparam int AW = $clog2(N)
)(
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data
);
   logic [W-1:0] regs [N];

   always_ff @(negedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (wr_en && wr_addr != '0) begin
         regs[wr_addr] <= wr_data;
      end
   end

   assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
   assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          NREG       = 32,
   parameter bit          HAS_MULDIV = 1'b1,
   parameter logic [31:0] RESET_PC   = 32'h0
)(
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   output logic            dmem_re,
   input  logic [XLEN-1:0] dmem_rdata
);
   localparam int RAW = $clog2(NREG);

   initial begin
      assert (XLEN == 32) else $error("sc_core: instruction format needs XLEN of 32");
      assert (NREG == 32) else $error("sc_core: register fields are 5 bits, NREG must be 32");
      assert (RESET_PC[1:0] == 2'b00) else $error("sc_core: RESET_PC must be word aligned");
   end

   logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, j_target;
   logic [5:0]      opcode, funct;
   logic [RAW-1:0]  rs_f, rt_f, rd_f, wr_addr;
   logic [4:0]      shamt;
   logic [XLEN-1:0] simm, ra_data, rb_data, alu_b, alu_y, wr_data;
   logic            alu_ok, wr_en, take_br;
   ctl_t            ctl;

   assign opcode = imem_rdata[31:26];
   assign rs_f   = imem_rdata[25:21];
   assign rt_f   = imem_rdata[20:16];
   assign rd_f   = imem_rdata[15:11];
   assign shamt  = imem_rdata[10:6];
   assign funct  = imem_rdata[5:0];
   assign simm   = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

   sc_decode u_dec (.opcode(opcode), .ctl(ctl));

   sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
      .clk(clk), .rst(rst),
      .ra_addr(rs_f), .ra_data(ra_data),
      .rb_addr(rt_f), .rb_data(rb_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   assign alu_b = ctl.src_imm ? simm : rb_data;

   sc_alu #(.W(XLEN), .HAS_MULDIV(HAS_MULDIV)) u_alu (
      .a(ra_data), .b(alu_b), .shamt(shamt), .funct(funct),
      .force_add(ctl.force_add), .y(alu_y), .ok(alu_ok)
   );

   assign wr_addr = ctl.dst_rd ? rd_f : rt_f;
   assign wr_data = ctl.mem_to_reg ? dmem_rdata : alu_y;
   assign wr_en   = ctl.reg_we & (~ctl.dst_rd | alu_ok);

   // next-PC selection
   assign pc_plus4  = pc_q + XLEN'(4);
   assign j_target  = {pc_plus4[XLEN-1:28], imem_rdata[25:0], 2'b00};
   assign br_target = pc_plus4 + {simm[XLEN-3:0], 2'b00};
   assign take_br   = ctl.is_branch & (ra_data == rb_data);
   assign pc_next   = ctl.is_jump ? j_target : (take_br ? br_target : pc_plus4);

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_next;
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rb_data;
   assign dmem_we    = ctl.mem_we;
   assign dmem_re    = ctl.mem_re;

   // R2
   pc_align_chk: assert property (@(posedge clk) disable iff (rst)
      imem_addr[1:0] == 2'b00);

   // R2
   pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
      (imem_rdata[31:26] != OP_JUMP && imem_rdata[31:26] != OP_BEQ)
      |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

   // R3
   jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
      (imem_rdata[31:26] == OP_JUMP)
      |=> (imem_addr == {$past(pc_plus4[XLEN-1:28]), $past(imem_rdata[25:0]), 2'b00}));

   // R12
   mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(dmem_we && dmem_re));

   // R12
   store_only_chk: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (imem_rdata[31:26] == OP_SW));

   // R10
   load_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (imem_rdata[31:26] == OP_LW) |-> (dmem_re && !dmem_we));
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, dmem_re;

   always #10 clk = ~clk;

   sc_core dut_i (
      .clk(clk), .rst(rst),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
      .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
   );

   logic [31:0] prog [64];
   string       ptag [64];
   logic [31:0] dmem [64];
   logic [31:0] rr   [32];
   logic [31:0] ref_pc;
   int          n_cmp = 0;
   int          n_bad = 0;

   assign imem_rdata = prog[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   function automatic logic [31:0] e_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
   endfunction
   function automatic logic [31:0] e_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction
   function automatic logic [31:0] e_j(int idx);
      return {6'b000010, 26'(idx)};
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (pc %h)", tag, what, act, exp, ref_pc);
      end
   endtask

   task automatic ref_reset();
      ref_pc = 32'h0;
      for (int i = 0; i < 32; i++) rr[i] = 32'h0;
   endtask

   // behavioural model of one instruction, compared at the ports
   task automatic exec();
      logic [31:0] ins, a, b, simm, npc, val, addr;
      logic [5:0]  op, fn;
      logic        e_we, e_re, valid;
      string       tag;
      ins  = prog[ref_pc[7:2]];
      tag  = ptag[ref_pc[7:2]];
      op   = ins[31:26];
      fn   = ins[5:0];
      a    = rr[ins[25:21]];
      b    = rr[ins[20:16]];
      simm = {{16{ins[15]}}, ins[15:0]};
      npc  = ref_pc + 4;
      e_we = 1'b0;
      e_re = 1'b0;
      addr = a + simm;
      chk(imem_addr == ref_pc, tag, "fetch address", imem_addr, ref_pc);
      case (op)
         6'b000000: begin
            valid = 1'b1;
            case (fn)
               6'b100000: val = a + b;
               6'b100010: val = a - b;
               6'b001101: val = a & b;
               6'b001111: val = a | b;
               6'b001011: val = ~b;
               6'b000010: val = b << ins[10:6];
               6'b000011: val = b >> ins[10:6];
               6'b011000: val = a * b;
               6'b011011: val = (b == 0) ? 32'hFFFF_FFFF : a / b;
               default:   begin val = 32'h0; valid = 1'b0; end
            endcase
            if (valid) rr[ins[15:11]] = val;
         end
         6'b000010: npc = {npc[31:28], ins[25:0], 2'b00};
         6'b001100, 6'b001111: rr[ins[20:16]] = addr;
         6'b011101: if (a == b) npc = npc + {simm[29:0], 2'b00};
         6'b100011: begin e_re = 1'b1; rr[ins[20:16]] = dmem[addr[7:2]]; end
         6'b101011: e_we = 1'b1;
         default: ;
      endcase
      rr[0] = 32'h0;
      chk(dmem_we == e_we, tag, "store strobe", {31'b0, dmem_we}, {31'b0, e_we});
      chk(dmem_re == e_re, tag, "load strobe", {31'b0, dmem_re}, {31'b0, e_re});
      if (e_we || e_re) chk(dmem_addr == addr, tag, "data address", dmem_addr, addr);
      if (e_we) chk(dmem_wdata == b, tag, "store data", dmem_wdata, b);
      if (dmem_we) dmem[dmem_addr[7:2]] = dmem_wdata;
      ref_pc = npc;
   endtask

   task automatic cycle(bit hold_rst);
      @(posedge clk);
      #5;
      if (rst) begin
         chk(imem_addr == 32'h0, "R1", "reset fetch address", imem_addr, 32'h0);
         ref_reset();
         if (!hold_rst) begin
            rst = 1'b0;
            exec();
         end
      end else begin
         exec();
         if (hold_rst) rst = 1'b1;
      end
   endtask

   initial begin
      string rtag [14];
      rtag = '{"R11", "R13", "R9", "R5", "R5", "R5", "R5", "R5",
               "R6", "R6", "R7", "R7", "R7", "R8"};
      for (int i = 0; i < 64; i++) begin
         prog[i] = 32'h0;
         ptag[i] = "R2";
         dmem[i] = 32'h0;
      end
      ref_reset();
      prog[1]  = e_i(6'b101011, 0, 5, 0);            ptag[1]  = "R1";
      prog[2]  = e_i(6'b001100, 0, 1, 5);            ptag[2]  = "R9";
      prog[3]  = e_i(6'b001111, 0, 2, -3);           ptag[3]  = "R9";
      prog[4]  = e_i(6'b001100, 1, 1, 7);            ptag[4]  = "R13";
      prog[5]  = e_r(1, 2, 3, 0, 6'b100000);         ptag[5]  = "R5";
      prog[6]  = e_r(1, 2, 4, 0, 6'b100010);         ptag[6]  = "R5";
      prog[7]  = e_r(1, 2, 5, 0, 6'b001101);         ptag[7]  = "R5";
      prog[8]  = e_r(1, 2, 6, 0, 6'b001111);         ptag[8]  = "R5";
      prog[9]  = e_r(0, 1, 7, 0, 6'b001011);         ptag[9]  = "R5";
      prog[10] = e_r(0, 2, 8, 4, 6'b000010);         ptag[10] = "R6";
      prog[11] = e_r(0, 2, 9, 28, 6'b000011);        ptag[11] = "R6";
      prog[12] = e_r(1, 2, 10, 0, 6'b011000);        ptag[12] = "R7";
      prog[13] = e_r(2, 1, 11, 0, 6'b011011);        ptag[13] = "R7";
      prog[14] = e_r(1, 0, 12, 0, 6'b011011);        ptag[14] = "R7";
      prog[15] = e_r(1, 1, 13, 0, 6'b111111);        ptag[15] = "R8";
      prog[16] = e_i(6'b001100, 1, 0, 99);           ptag[16] = "R11";
      prog[17] = e_i(6'b111111, 1, 13, 42);          ptag[17] = "R12";
      for (int x = 1; x <= 13; x++) begin
         prog[17 + x] = e_i(6'b101011, 0, x, 4 * x);
         ptag[17 + x] = rtag[x];
      end
      prog[31] = e_i(6'b101011, 0, 0, 56);           ptag[31] = "R11";
      prog[32] = e_i(6'b100011, 1, 15, -8);          ptag[32] = "R10";
      prog[33] = e_i(6'b100011, 1, 14, 12);          ptag[33] = "R10";
      prog[34] = e_i(6'b011101, 14, 6, 1);           ptag[34] = "R4";
      prog[35] = e_i(6'b001100, 0, 20, 1);           ptag[35] = "R4";
      prog[36] = e_i(6'b011101, 1, 2, 5);            ptag[36] = "R4";
      prog[37] = e_j(40);                            ptag[37] = "R3";
      prog[38] = e_i(6'b001100, 0, 21, 1);           ptag[38] = "R3";
      prog[40] = e_i(6'b101011, 0, 20, 80);          ptag[40] = "R4";
      prog[41] = e_i(6'b101011, 0, 15, 84);          ptag[41] = "R10";
      prog[42] = e_i(6'b101011, 0, 21, 88);          ptag[42] = "R3";
      prog[43] = e_i(6'b011101, 0, 0, -1);           ptag[43] = "R4";

      repeat (3) cycle(1'b1);
      cycle(1'b0);
      repeat (60) cycle(1'b0);
      cycle(1'b1);
      repeat (2) cycle(1'b1);
      cycle(1'b0);
      repeat (6) cycle(1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 5000);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule